// File: doc/BRIEF.md
# Parallel NOR Flash Register Bridge

This block gives a host a small register window through which it reads, programs and erases a byte-wide parallel NOR flash with a 24-bit byte address. The host first stores one packed command word, which holds an address and a data byte. It then writes a request register with one of three one-hot requests: byte read, raw command write, or data program. The block runs the flash bus cycles on the chip-enable, output-enable and write-enable pins. It drops the request bit when the access has finished. The host polls that register until it reads zero.

A raw command write places exactly one byte on the bus. The host builds erase sequences from six of these writes. The block watches the completed raw writes. When the sixth write of a chip or sector erase lands, it raises a busy status bit. The block then polls the flash by itself until the erase is finished. A data program is one request. The block sends the three-write unlock and program-setup prefix, then the data byte, and it holds the request until the flash reports that the byte has been written. Polling that never resolves sets a sticky error bit.

Top module: `flash_reg_bridge`

## Requirements
- R1: After reset, the request register, the busy bit and the error bit read zero, and chip enable, output enable and write enable are all high.
- R2: A raw command write drives command-word bits 23:0 on the flash address pins and bits 31:24 on the flash data pins. Both stay constant while write enable is low.
- R3: A read request (request value 3'b001, written at register index 1) stores the flash byte at the command address. Register index 2 returns that byte in bits 7:0, and bits 31:8 read zero.
- R4: The request register holds at most one set bit. A write whose low three bits are not one-hot is ignored. The set bit clears by itself when the access completes.
- R5: A program request (3'b100) issues, in order, 0xAA at address 0x005555, 0x55 at 0x002AAA, 0xA0 at 0x005555, and then the data byte at the command address.
- R6: After the data byte of a program, the block reads the command address repeatedly. The program request clears only once bit 7 of the read data equals bit 7 of the programmed byte.
- R7: Status word index 3, bit 3 (busy) goes high as the raw request clears when that raw write completes the erase sequence 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, followed by 0x10@0x5555 (chip) or 0x30 at any address (sector). Only address bits 14:0 are compared. Busy falls once a poll read of the last write address returns bit 7 high.
- R8: A request write arriving while a request is pending, or while busy is high, is ignored. This includes a write in the very cycle the pending request completes.
- R9: If POLL_MAX poll reads pass without a match, the block sets bit 4 of the status word and clears the request bit or the busy bit. The error bit stays set until reset.
- R10: Each write-enable pulse lasts exactly T_STROBE clock cycles. Output enable and write enable are never low together, and chip enable is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register index: 0 command word, 1 request, 2 read data, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_dq_out | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Enable for the flash data drivers |
| flash_dq_in | input | 8 | Data returned by the flash |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
Two events can meet in one clock edge: the completion of a pending request and a new host write to the request register. The bench provokes this by writing a raw request on every cycle while a read is in flight, and it stops only when it sees the request register at zero. So the last write always lands on the completion edge. The result counts as correct when the register then stays at zero and the flash model records no extra write. A second collision, a request written while an erase is being polled, is judged the same way.

// File: rtl/flash_bridge_pkg.sv
package flash_bridge_pkg;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_SETUP,
    BC_STROBE,
    BC_HOLD,
    BC_DONE
  } bus_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_RAW,
    OP_PROG
  } op_t;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_ISSUE,
    EN_WAIT,
    EN_POLL_ISSUE,
    EN_POLL_WAIT
  } eng_state_t;

  localparam logic [7:0] CODE_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK2 = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;

  localparam logic [15:0] OFS_A = 16'h5555;
  localparam logic [15:0] OFS_B = 16'h2AAA;

  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_REQ   = 2'd1;
  localparam logic [1:0] SEL_RDATA = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int REQ_READ  = 0;
  localparam int REQ_RAW   = 1;
  localparam int REQ_PROG  = 2;
  localparam int STAT_BUSY = 3;
  localparam int STAT_ERR  = 4;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_bridge_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_dq_out,
  output logic              f_dq_oe,
  input  logic [DATA_W-1:0] f_dq_in,
  output logic              f_ce_n,
  output logic              f_oe_n,
  output logic              f_we_n
);

  localparam int T_SH  = (T_SETUP > T_HOLD) ? T_SETUP : T_HOLD;
  localparam int T_MAX = (T_SH > T_STROBE) ? T_SH : T_STROBE;
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(T_STROBE - 1);
  localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(T_HOLD - 1);

  bus_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic              ld_en;
  logic              cap_en;
  logic              active;

  // next-state process
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ld_en  = 1'b0;
    cap_en = 1'b0;
    case (st_q)
      BC_IDLE: begin
        if (start) begin
          ld_en = 1'b1;
          st_d  = BC_SETUP;
          cnt_d = LD_SETUP;
        end
      end
      BC_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = BC_STROBE;
          cnt_d = LD_STROBE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BC_STROBE: begin
        if (cnt_q == '0) begin
          cap_en = ~wr_q;
          st_d   = BC_HOLD;
          cnt_d  = LD_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BC_HOLD: begin
        if (cnt_q == '0) begin
          st_d = BC_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = BC_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_en) begin
      wr_q   <= is_write;
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= f_dq_in;
    end
  end

  assign active   = (st_q == BC_SETUP) || (st_q == BC_STROBE) || (st_q == BC_HOLD);
  assign f_ce_n   = ~active;
  assign f_we_n   = ~((st_q == BC_STROBE) && wr_q);
  assign f_oe_n   = ~((st_q == BC_STROBE) && ~wr_q);
  assign f_dq_oe  = active && wr_q;
  assign f_addr   = addr_q;
  assign f_dq_out = data_q;
  assign done     = (st_q == BC_DONE);
  assign rd_data  = rd_q;

endmodule

// File: rtl/flash_erase_detect.sv
module flash_erase_detect
  import flash_bridge_pkg::*;
#(
  parameter int MATCH_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_evt,
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [7:0]         data,
  output logic               hit
);

  localparam logic [MATCH_W-1:0] MA = OFS_A[MATCH_W-1:0];
  localparam logic [MATCH_W-1:0] MB = OFS_B[MATCH_W-1:0];

  logic [2:0] stage_q, stage_d;
  logic       at_a, at_b;
  logic       step_ok;
  logic       restart;

  assign at_a = (addr_lo == MA);
  assign at_b = (addr_lo == MB);

  always_comb begin
    case (stage_q)
      3'd0:    step_ok = at_a && (data == CODE_UNLOCK1);
      3'd1:    step_ok = at_b && (data == CODE_UNLOCK2);
      3'd2:    step_ok = at_a && (data == CODE_ERASE);
      3'd3:    step_ok = at_a && (data == CODE_UNLOCK1);
      3'd4:    step_ok = at_b && (data == CODE_UNLOCK2);
      default: step_ok = 1'b0;
    endcase
  end

  assign hit     = (stage_q == 3'd5) &&
                   ((at_a && (data == CODE_CHIP)) || (data == CODE_SECTOR));
  assign restart = at_a && (data == CODE_UNLOCK1);

  always_comb begin
    stage_d = stage_q;
    if (wr_evt) begin
      if (hit)          stage_d = 3'd0;
      else if (step_ok) stage_d = stage_q + 3'd1;
      else if (restart) stage_d = 3'd1;
      else              stage_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 3'd0;
    else if (wr_evt) stage_q <= stage_d;
  end

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_bridge_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int POLL_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_t               op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              bus_start,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_done,
  input  logic              bus_rd7,
  input  logic              erase_hit,
  output logic              raw_wr_evt,
  output logic              req_done,
  output logic              rd_valid,
  output logic              busy,
  output logic              err_set
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  eng_state_t        st_q, st_d;
  op_t               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [1:0]        step_q, step_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              exp7_q, exp7_d;
  logic              busy_q, busy_d;
  logic              ld_en;
  logic              last_step;
  logic              polling;
  logic [ADDR_W-1:0] step_addr;
  logic [7:0]        step_data;

  // address/data of the current write step
  always_comb begin
    step_addr = addr_q;
    step_data = data_q;
    if (op_q == OP_PROG) begin
      case (step_q)
        2'd0: begin step_addr = ADDR_W'(OFS_A); step_data = CODE_UNLOCK1; end
        2'd1: begin step_addr = ADDR_W'(OFS_B); step_data = CODE_UNLOCK2; end
        2'd2: begin step_addr = ADDR_W'(OFS_A); step_data = CODE_PROG;    end
        default: ;
      endcase
    end
  end

  assign last_step = (op_q != OP_PROG) || (step_q == 2'd3);
  assign polling   = (st_q == EN_POLL_ISSUE) || (st_q == EN_POLL_WAIT);
  assign bus_addr  = polling ? addr_q : step_addr;
  assign bus_wdata = step_data;
  assign bus_start = (st_q == EN_ISSUE) || (st_q == EN_POLL_ISSUE);
  assign bus_write = (st_q == EN_ISSUE) && (op_q != OP_READ);

  // next-state process
  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    poll_d     = poll_q;
    exp7_d     = exp7_q;
    busy_d     = busy_q;
    ld_en      = 1'b0;
    raw_wr_evt = 1'b0;
    req_done   = 1'b0;
    rd_valid   = 1'b0;
    err_set    = 1'b0;
    case (st_q)
      EN_IDLE: begin
        if (start) begin
          ld_en  = 1'b1;
          step_d = 2'd0;
          st_d   = EN_ISSUE;
        end
      end
      EN_ISSUE: st_d = EN_WAIT;
      EN_WAIT: begin
        if (bus_done) begin
          if (!last_step) begin
            step_d = step_q + 2'd1;
            st_d   = EN_ISSUE;
          end else begin
            poll_d = '0;
            case (op_q)
              OP_READ: begin
                rd_valid = 1'b1;
                req_done = 1'b1;
                st_d     = EN_IDLE;
              end
              OP_RAW: begin
                raw_wr_evt = 1'b1;
                req_done   = 1'b1;
                if (erase_hit) begin
                  busy_d = 1'b1;
                  exp7_d = 1'b1;
                  st_d   = EN_POLL_ISSUE;
                end else begin
                  st_d = EN_IDLE;
                end
              end
              default: begin
                exp7_d = data_q[7];
                st_d   = EN_POLL_ISSUE;
              end
            endcase
          end
        end
      end
      EN_POLL_ISSUE: st_d = EN_POLL_WAIT;
      EN_POLL_WAIT: begin
        if (bus_done) begin
          if ((bus_rd7 == exp7_q) || (poll_q == POLL_LAST)) begin
            err_set  = (bus_rd7 != exp7_q);
            req_done = (op_q == OP_PROG);
            busy_d   = 1'b0;
            st_d     = EN_IDLE;
          end else begin
            poll_d = poll_q + 1'b1;
            st_d   = EN_POLL_ISSUE;
          end
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      step_q <= 2'd0;
      poll_q <= '0;
      exp7_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      poll_q <= poll_d;
      exp7_q <= exp7_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_en) begin
      op_q   <= op;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/flash_reg_bridge.sv
module flash_reg_bridge
  import flash_bridge_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int T_SETUP  = 1,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 1,
  parameter int POLL_MAX = 64,
  parameter int MATCH_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);

  localparam int DATA_LSB = 24;

  logic [1:0]        rst_sync_q;
  logic              arst_n;
  logic [31:0]       cmd_q;
  logic [2:0]        req_q, req_d;
  logic [7:0]        rd_q;
  logic              err_q;
  logic              cmd_en, req_en, rd_en, err_en;
  logic              req_wr, req_onehot, accept;
  op_t               start_op;

  logic              bus_start, bus_write, bus_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic              erase_hit, raw_wr_evt;
  logic              req_done, rd_valid, eng_busy, err_set;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  // request admission
  assign req_wr     = host_we && (host_sel == SEL_REQ);
  assign req_onehot = (host_wdata[2:0] == 3'b001) || (host_wdata[2:0] == 3'b010) ||
                      (host_wdata[2:0] == 3'b100);
  assign accept     = req_wr && req_onehot && (req_q == 3'b000) && !eng_busy;

  always_comb begin
    if (host_wdata[REQ_READ])      start_op = OP_READ;
    else if (host_wdata[REQ_RAW])  start_op = OP_RAW;
    else                           start_op = OP_PROG;
  end

  always_comb begin
    req_d = req_q;
    if (req_done)    req_d = 3'b000;
    else if (accept) req_d = host_wdata[2:0];
  end

  assign cmd_en = host_we && (host_sel == SEL_CMD);
  assign req_en = req_done || accept;
  assign rd_en  = rd_valid;
  assign err_en = err_set;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cmd_q <= '0;
    else if (cmd_en) cmd_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) req_q <= 3'b000;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rd_q <= 8'h00;
    else if (rd_en) rd_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) err_q <= 1'b0;
    else if (err_en) err_q <= 1'b1;
  end

  // register read mux
  always_comb begin
    host_rdata = 32'h0;
    case (host_sel)
      SEL_CMD:   host_rdata = cmd_q;
      SEL_REQ:   host_rdata[2:0] = req_q;
      SEL_RDATA: host_rdata[7:0] = rd_q;
      default: begin
        host_rdata[STAT_BUSY] = eng_busy;
        host_rdata[STAT_ERR]  = err_q;
      end
    endcase
  end

  flash_op_engine #(
    .ADDR_W   (ADDR_W),
    .POLL_MAX (POLL_MAX)
  ) u_engine (
    .clk        (clk),
    .rst_n      (arst_n),
    .start      (accept),
    .op         (start_op),
    .cmd_addr   (cmd_q[ADDR_W-1:0]),
    .cmd_data   (cmd_q[DATA_LSB +: 8]),
    .bus_start  (bus_start),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_done   (bus_done),
    .bus_rd7    (bus_rdata[7]),
    .erase_hit  (erase_hit),
    .raw_wr_evt (raw_wr_evt),
    .req_done   (req_done),
    .rd_valid   (rd_valid),
    .busy       (eng_busy),
    .err_set    (err_set)
  );

  flash_erase_detect #(
    .MATCH_W (MATCH_W)
  ) u_erase (
    .clk     (clk),
    .rst_n   (arst_n),
    .wr_evt  (raw_wr_evt),
    .addr_lo (bus_addr[MATCH_W-1:0]),
    .data    (bus_wdata),
    .hit     (erase_hit)
  );

  flash_bus_cycle #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (8),
    .T_SETUP  (T_SETUP),
    .T_STROBE (T_STROBE),
    .T_HOLD   (T_HOLD)
  ) u_bus (
    .clk      (clk),
    .rst_n    (arst_n),
    .start    (bus_start),
    .is_write (bus_write),
    .addr_in  (bus_addr),
    .data_in  (bus_wdata),
    .done     (bus_done),
    .rd_data  (bus_rdata),
    .f_addr   (flash_addr),
    .f_dq_out (flash_dq_out),
    .f_dq_oe  (flash_dq_oe),
    .f_dq_in  (flash_dq_in),
    .f_ce_n   (flash_ce_n),
    .f_oe_n   (flash_oe_n),
    .f_we_n   (flash_we_n)
  );

endmodule

// File: rtl/flash_bridge_checker.sv
module flash_bridge_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [1:0]        host_sel,
  input logic [2:0]        req,
  input logic              busy,
  input logic              err,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out
);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((req == 3'b000) && !busy) |-> (ce_n && oe_n && we_n));

  p_we_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out)));

  p_req_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (req == 3'b000));

  p_ignore_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && (host_sel == 2'd1) && ((req != 3'b000) || busy))
      |=> ((req == $past(req)) || (req == 3'b000)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_ce_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !ce_n);

endmodule

bind flash_reg_bridge flash_bridge_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_we  (host_we),
  .host_sel (host_sel),
  .req      (req_q),
  .busy     (eng_busy),
  .err      (err_q),
  .ce_n     (flash_ce_n),
  .oe_n     (flash_oe_n),
  .we_n     (flash_we_n),
  .addr     (flash_addr),
  .dq_out   (flash_dq_out)
);

// File: tb/flash_reg_bridge_test.sv
module flash_reg_bridge_test;

  localparam int T_STROBE   = 2;
  localparam int POLL_MAX   = 64;
  localparam int PROG_BUSY  = 5;
  localparam int ERASE_BUSY = 20;

  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic [1:0]  host_sel;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [23:0] flash_addr;
  logic [7:0]  flash_dq_out;
  logic        flash_dq_oe;
  logic [7:0]  flash_dq_in;
  logic        flash_ce_n, flash_oe_n, flash_we_n;

  int errors = 0;
  int checks = 0;

  // flash model state
  logic [7:0]  mem [0:4095];
  int          ustage = 0;
  bit          prog_armed = 0;
  int          busy_reads = 0;
  bit          poll7 = 1'b1;
  bit          stuck = 0;
  int          wr_count = 0;
  logic [23:0] wa [0:3];
  logic [7:0]  wd [0:3];
  logic        prev_we = 1'b1, prev_oe = 1'b1;
  int          we_len = 0, we_pulses = 0, we_bad = 0, overlap_bad = 0;

  flash_reg_bridge #(
    .ADDR_W(24), .T_SETUP(1), .T_STROBE(T_STROBE), .T_HOLD(1),
    .POLL_MAX(POLL_MAX), .MATCH_W(15)
  ) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign flash_dq_in = flash_oe_n ? 8'h00 :
                       ((busy_reads > 0) ? {~poll7, 7'h2A} : mem[flash_addr[11:0]]);

  function automatic void model_write(input logic [23:0] a, input logic [7:0] d);
    bit is_a = (a[14:0] == 15'h5555);
    bit is_b = (a[14:0] == 15'h2AAA);
    bit rs   = is_a && (d == 8'hAA);
    if (prog_armed) begin
      mem[a[11:0]] = mem[a[11:0]] & d;
      prog_armed = 0; busy_reads = PROG_BUSY; poll7 = d[7]; ustage = 0;
    end else begin
      case (ustage)
        0: ustage = rs ? 1 : 0;
        1: ustage = (is_b && d == 8'h55) ? 2 : (rs ? 1 : 0);
        2: if (is_a && d == 8'hA0) begin prog_armed = 1; ustage = 0; end
           else if (is_a && d == 8'h80) ustage = 3;
           else ustage = rs ? 1 : 0;
        3: ustage = rs ? 4 : 0;
        4: ustage = (is_b && d == 8'h55) ? 5 : (rs ? 1 : 0);
        default: begin
          if (is_a && d == 8'h10) begin
            for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
            busy_reads = ERASE_BUSY; poll7 = 1'b1; ustage = 0;
          end else if (d == 8'h30) begin
            for (int i = 0; i < 256; i++) mem[{a[11:8], 8'h00} + i] = 8'hFF;
            busy_reads = ERASE_BUSY; poll7 = 1'b1; ustage = 0;
          end else ustage = rs ? 1 : 0;
        end
      endcase
    end
  endfunction

  always @(negedge clk) begin
    if (!flash_we_n && !flash_oe_n) overlap_bad++;
    if (!flash_we_n && flash_ce_n) overlap_bad++;
    if (!flash_we_n) we_len++;
    if (prev_we == 1'b0 && flash_we_n == 1'b1) begin
      we_pulses++;
      if (we_len != T_STROBE) we_bad++;
      we_len = 0;
      for (int k = 3; k > 0; k--) begin wa[k] = wa[k-1]; wd[k] = wd[k-1]; end
      wa[0] = flash_addr; wd[0] = flash_dq_out;
      wr_count++;
      model_write(flash_addr, flash_dq_out);
    end
    if (prev_oe == 1'b0 && flash_oe_n == 1'b1) begin
      if (busy_reads > 0 && !stuck) busy_reads--;
    end
    prev_we = flash_we_n;
    prev_oe = flash_oe_n;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    host_sel = s;
    #1 v = host_rdata;
  endtask

  task automatic wait_req_clear();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      hread(2'd1, v);
      if (v[2:0] == 3'b000) break;
    end
  endtask

  task automatic wait_busy_clear();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      hread(2'd3, v);
      if (v[3] == 1'b0) break;
    end
  endtask

  task automatic do_op(input logic [2:0] r, input logic [23:0] a, input logic [7:0] d);
    hwrite(2'd0, {d, a});
    hwrite(2'd1, {29'd0, r});
    wait_req_clear();
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] v);
    do_op(3'b001, a, 8'h00);
    hread(2'd2, v);
  endtask

  function automatic logic [31:0] exp_read(input logic [23:0] a);
    return {24'h0, mem[a[11:0]]};
  endfunction

  task automatic erase_prefix();
    do_op(3'b010, 24'h005555, 8'hAA);
    do_op(3'b010, 24'h002AAA, 8'h55);
    do_op(3'b010, 24'h005555, 8'h80);
    do_op(3'b010, 24'h005555, 8'hAA);
    do_op(3'b010, 24'h002AAA, 8'h55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [23:0] a;
    logic [7:0]  d;
    int          wc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    host_we = 0; host_sel = 0; host_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    hread(2'd1, v); check("R1 request reg", v, 32'h0);
    hread(2'd3, v); check("R1 status reg", v, 32'h0);
    check("R1 strobes idle", {29'd0, flash_ce_n, flash_oe_n, flash_we_n}, 32'h7);

    // R3 random reads
    for (int i = 0; i < 8; i++) begin
      a = 24'($urandom);
      do_read(a, v);
      check("R3 read byte", v, exp_read(a));
    end
    do_read(24'h000000, v); check("R3 read lowest", v, exp_read(24'h000000));
    do_read(24'hFFFFFF, v); check("R3 read highest", v, exp_read(24'hFFFFFF));

    // R2 raw write packing, R4 self-clear
    wc = wr_count;
    do_op(3'b010, 24'h123456, 8'h5A);
    check("R2 raw write count", wr_count - wc, 1);
    check("R2 raw addr", {8'h0, wa[0]}, 32'h00123456);
    check("R2 raw data", {24'h0, wd[0]}, 32'h5A);
    hread(2'd1, v); check("R4 request self-clear", v, 32'h0);

    // R4 non-one-hot request ignored
    hwrite(2'd1, 32'h3);
    hread(2'd1, v); check("R4 non-onehot ignored", v, 32'h0);

    // R7 chip erase, R8 request during busy
    erase_prefix();
    do_op(3'b010, 24'h005555, 8'h10);
    hread(2'd3, v); check("R7 busy after chip erase", v, 32'h8);
    hwrite(2'd1, 32'h1);
    hread(2'd1, v); check("R8 request ignored while busy", v, 32'h0);
    wait_busy_clear();
    hread(2'd3, v); check("R7 busy falls", v, 32'h0);
    check("R7 model drained", busy_reads, 0);
    do_read(24'h000ABC, v); check("R7 chip erased", v, 32'hFF);

    // R5 R6 constrained random programs
    for (int i = 0; i < 6; i++) begin
      a = 24'h000600 + 24'(i * 8) + 24'($urandom_range(0, 7));
      d = 8'($urandom);
      if (i == 0) d = 8'h00;
      if (i == 1) d = 8'hFE;
      wc = wr_count;
      do_op(3'b100, a, d);
      check("R6 flash ready at clear", busy_reads, 0);
      check("R5 write count", wr_count - wc, 4);
      check("R5 first unlock", {wd[3], wa[3]}, 32'hAA005555);
      check("R5 second unlock", {wd[2], wa[2]}, 32'h55002AAA);
      check("R5 setup code", {wd[1], wa[1]}, 32'hA0005555);
      check("R5 data write", {wd[0], wa[0]}, {d, a});
      do_read(a, v); check("R6 programmed value", v, {24'h0, d});
    end

    // R8 request while another pending
    wc = wr_count;
    hwrite(2'd0, {8'h00, 24'h000640});
    hwrite(2'd1, 32'h1);
    hwrite(2'd1, 32'h4);
    hread(2'd1, v); check("R8 pending keeps read", v, 32'h1);
    wait_req_clear();
    repeat (20) @(negedge clk);
    check("R8 no program issued", wr_count - wc, 0);

    // R8 write on the completion edge
    wc = wr_count;
    hwrite(2'd0, {8'h00, 24'h000010});
    hwrite(2'd1, 32'h1);
    host_sel = 2'd1;
    for (int k = 0; k < 2000; k++) begin
      #1 v = host_rdata;
      if (v[2:0] == 3'b000) break;
      host_we = 1'b1; host_wdata = 32'h2;
      @(negedge clk);
      host_we = 1'b0;
    end
    repeat (20) @(negedge clk);
    hread(2'd1, v); check("R8 collision request", v, 32'h0);
    check("R8 collision no write", wr_count - wc, 0);

    // R7 sector erase
    do_op(3'b100, 24'h0002FF, 8'h12);
    do_op(3'b100, 24'h0003A5, 8'h00);
    erase_prefix();
    do_op(3'b010, 24'h000300, 8'h30);
    hread(2'd3, v); check("R7 busy after sector erase", v, 32'h8);
    wait_busy_clear();
    do_read(24'h0003A5, v); check("R7 sector erased", v, 32'hFF);
    do_read(24'h0002FF, v); check("R7 outside sector kept", v, 32'h12);

    // R9 poll timeout and sticky error
    stuck = 1;
    do_op(3'b100, 24'h000900, 8'h00);
    hread(2'd3, v); check("R9 error after timeout", v, 32'h10);
    stuck = 0; busy_reads = 0;
    do_read(24'h000ABC, v); check("R9 read after timeout", v, exp_read(24'h000ABC));
    hread(2'd3, v); check("R9 error sticky", v, 32'h10);

    // R10 strobe timing
    check("R10 strobe width errors", we_bad, 0);
    check("R10 strobe overlap", overlap_bad, 0);
    check("R10 pulses seen", {31'd0, we_pulses > 20}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule